// File: doc/BRIEF.md
# Write Enable and Region Lock Guard

This block sits beside the serial command decoder of a small nonvolatile memory. It decides, one system clock at a time, whether a nonvolatile write may begin. It holds two pieces of state: the write-enable latch, and a 3-bit lock code that names one protected address range. The decoder does not pass it serial bits. It passes event pulses instead: an enable command has finished, a further bit has arrived, the select line has gone inactive, a disable command has arrived, the internal write cycle is complete. It also passes the level of the hardware write-allow pin and a flag that is high while a write or lock sequence is being shifted in.

When a sequence ends at a valid boundary, the decoder raises a go pulse for either an array write (with the target address) or a lock-code load (with the new code). The guard answers one cycle later with a start pulse, or with no pulse if the request is refused. The lock code is also decoded into an enable flag and an inclusive lower and upper address, so that other logic can see which range is protected.

Top module: `wr_guard`

## Requirements
- R1: After reset, the latch reads 0, the lock code reads 000 (no protection, `prot_en` = 0), and neither `wr_start` nor `lock_start` is high.
- R2: The latch is set on the clock edge of a `desel_edge` pulse only if an `arm_cmd` pulse came before it with no `bit_tick` in between. An `arm_cmd` followed by a `bit_tick` leaves the latch clear.
- R3: A `disarm_cmd` or `nv_done` pulse clears the latch on the next edge, and clearing wins over setting.
- R4: Lock codes 000 to 100 decode to: no range (`prot_en` = 0), 000h-0FFh, 100h-1FFh, 200h-2FFh and 300h-3FFh, with the default 10-bit address.
- R5: Lock codes 101, 110 and 111 decode to 000h-1FFh, 000h-00Fh and 3F0h-3FFh in turn.
- R6: `wr_start` is high in the cycle after `wr_go` exactly when the latch is set, `hw_allow` is high, no abort is pending, and the 16-byte page that holds `wr_addr` lies outside the protected range. Any byte of a locked page refuses the whole write.
- R7: While `hw_allow` is low, every array write and every lock load is refused, but setting and clearing the latch still work.
- R8: A high-to-low change of `hw_allow` while `shift_busy` is high refuses any go pulse until `shift_busy` drops, even if `hw_allow` returns high. A change while `shift_busy` is low, during an internal cycle, has no later effect.
- R9: A lock load (`lock_go`) needs the latch and `hw_allow`, but not the current range. When accepted, `lock_code` takes `lock_data` and `lock_start` pulses in the cycle after `lock_go`. Otherwise the code stays unchanged.
- R10: `wr_allowed` shows, in the same cycle, whether a `wr_go` at the present `wr_addr` would be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_allow | input | 1 | Hardware write-allow pin level, low blocks writes |
| shift_busy | input | 1 | High while a write or lock sequence is being shifted in |
| arm_cmd | input | 1 | Pulse: enable command fully received |
| bit_tick | input | 1 | Pulse: a further serial bit was received |
| desel_edge | input | 1 | Pulse: select line went inactive |
| disarm_cmd | input | 1 | Pulse: disable command received |
| nv_done | input | 1 | Pulse: internal nonvolatile cycle finished |
| wr_go | input | 1 | Pulse: array write sequence ended at a valid boundary |
| wr_addr | input | ADDR_W | Address of the first byte of the pending write |
| lock_go | input | 1 | Pulse: lock-load sequence ended at a valid boundary |
| lock_data | input | 3 | New lock code |
| wel | output | 1 | Write-enable latch |
| lock_code | output | 3 | Current lock code |
| prot_en | output | 1 | A range is protected |
| prot_lo | output | ADDR_W | Lowest protected address |
| prot_hi | output | ADDR_W | Highest protected address |
| wr_allowed | output | 1 | A write at `wr_addr` would be accepted now |
| wr_start | output | 1 | Pulse: array write accepted |
| lock_start | output | 1 | Pulse: lock load accepted |

## Verification
The hardest case to reach is the abort. It needs a falling edge of the pin during a shift, a return to high before the go pulse, and a latch that is still set, so that the abort alone explains the refusal. A directed sequence builds exactly this. It then drops `shift_busy` and shows that the next write goes through. A second directed sequence toggles the pin during an internal cycle and shows that nothing lingers. Random iterations with a fixed seed mix lock loads, armed and unarmed latches, pin levels and addresses, and compare each result with a range table held in the bench.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic [2:0] {
        LK_NONE     = 3'd0,
        LK_QUART0   = 3'd1,
        LK_QUART1   = 3'd2,
        LK_QUART2   = 3'd3,
        LK_QUART3   = 3'd4,
        LK_LOW_HALF = 3'd5,
        LK_FIRST_PG = 3'd6,
        LK_LAST_PG  = 3'd7
    } lock_code_e;

    localparam int unsigned RANGE_W = 16;

    typedef struct packed {
        logic               en;
        logic [RANGE_W-1:0] lo;
        logic [RANGE_W-1:0] hi;
    } prot_range_t;

    // Inclusive protected range for a code; aw = address bits, pw = page bits.
    function automatic prot_range_t decode_lock(lock_code_e c, int unsigned aw, int unsigned pw);
        prot_range_t        r;
        logic [RANGE_W-1:0] quart;
        logic [RANGE_W-1:0] top;
        logic [RANGE_W-1:0] page;
        quart = RANGE_W'(1) << (aw - 2);
        top   = (RANGE_W'(1) << aw) - RANGE_W'(1);
        page  = RANGE_W'(1) << pw;
        r     = '0;
        r.en  = 1'b1;
        case (c)
            LK_QUART0:   begin r.lo = '0;            r.hi = quart - 1'b1;            end
            LK_QUART1:   begin r.lo = quart;         r.hi = 2 * quart - 1'b1;        end
            LK_QUART2:   begin r.lo = 2 * quart;     r.hi = 3 * quart - 1'b1;        end
            LK_QUART3:   begin r.lo = 3 * quart;     r.hi = top;                     end
            LK_LOW_HALF: begin r.lo = '0;            r.hi = 2 * quart - 1'b1;        end
            LK_FIRST_PG: begin r.lo = '0;            r.hi = page - 1'b1;             end
            LK_LAST_PG:  begin r.lo = top - page + 1'b1; r.hi = top;                 end
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wel_latch.sv
module wel_latch (
    input  logic clk,
    input  logic rst,
    input  logic arm_cmd,
    input  logic bit_tick,
    input  logic desel_edge,
    input  logic disarm_cmd,
    input  logic nv_done,
    output logic wel
);
    logic pend_q;
    logic wel_q;

    // arm_cmd wins over a bit_tick in the same cycle (that tick is the command's last bit).
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            wel_q  <= 1'b0;
        end else begin
            if (arm_cmd)
                pend_q <= 1'b1;
            else if (bit_tick || desel_edge)
                pend_q <= 1'b0;

            if (disarm_cmd || nv_done)
                wel_q <= 1'b0;
            else if (desel_edge && pend_q && !bit_tick)
                wel_q <= 1'b1;
        end
    end

    assign wel = wel_q;

    assert_set_on_deselect_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wel_q) |-> $past(desel_edge));

    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (disarm_cmd || nv_done) |=> !wel_q);

endmodule

// File: rtl/hw_abort_track.sv
module hw_abort_track (
    input  logic clk,
    input  logic rst,
    input  logic hw_allow,
    input  logic shift_busy,
    output logic abort
);
    logic hw_q;
    logic abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q    <= 1'b1;
            abort_q <= 1'b0;
        end else begin
            hw_q <= hw_allow;
            if (!shift_busy)
                abort_q <= 1'b0;
            else if (hw_q && !hw_allow)
                abort_q <= 1'b1;
        end
    end

    assign abort = abort_q;

    assert_abort_only_in_shift_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(abort_q) |-> $past(shift_busy));

endmodule

// File: rtl/lock_region.sv
module lock_region
    import guard_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PAGE_W     = 4,
    parameter bit          COLD_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [2:0]        load_code,
    input  logic [ADDR_W-1:0] chk_addr,
    output lock_code_e        code,
    output prot_range_t       rng,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);

    lock_code_e        code_q;
    logic [ADDR_W-1:0] page_base;
    logic [ADDR_W-1:0] lo_a;
    logic [ADDR_W-1:0] hi_a;

    generate
        if (COLD_RESET) begin : g_cold
            always_ff @(posedge clk) begin
                if (rst)       code_q <= LK_NONE;
                else if (load) code_q <= lock_code_e'(load_code);
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (load) code_q <= lock_code_e'(load_code);
            end
        end
    endgenerate

    always_comb begin
        rng       = decode_lock(code_q, ADDR_W, PAGE_W);
        lo_a      = rng.lo[ADDR_W-1:0];
        hi_a      = rng.hi[ADDR_W-1:0];
        page_base = chk_addr & ~PAGE_MASK;
        hit       = rng.en && (page_base >= lo_a) && (page_base <= hi_a);
    end

    assign code = code_q;

    assert_range_order_R4: assert property (@(posedge clk) disable iff (rst)
        rng.en |-> (rng.hi >= rng.lo));

endmodule

// File: rtl/wr_guard.sv
module wr_guard
    import guard_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PAGE_W     = 4,
    parameter bit          COLD_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_allow,
    input  logic              shift_busy,
    input  logic              arm_cmd,
    input  logic              bit_tick,
    input  logic              desel_edge,
    input  logic              disarm_cmd,
    input  logic              nv_done,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              lock_go,
    input  logic [2:0]        lock_data,
    output logic              wel,
    output logic [2:0]        lock_code,
    output logic              prot_en,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi,
    output logic              wr_allowed,
    output logic              wr_start,
    output logic              lock_start
);
    lock_code_e  code;
    prot_range_t rng;
    logic        hit;
    logic        abort;
    logic        lock_ok;
    logic        wr_start_q;
    logic        lock_start_q;

    wel_latch u_wel (
        .clk        (clk),
        .rst        (rst),
        .arm_cmd    (arm_cmd),
        .bit_tick   (bit_tick),
        .desel_edge (desel_edge),
        .disarm_cmd (disarm_cmd),
        .nv_done    (nv_done),
        .wel        (wel)
    );

    hw_abort_track u_abort (
        .clk        (clk),
        .rst        (rst),
        .hw_allow   (hw_allow),
        .shift_busy (shift_busy),
        .abort      (abort)
    );

    lock_region #(
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .COLD_RESET (COLD_RESET)
    ) u_lock (
        .clk       (clk),
        .rst       (rst),
        .load      (lock_go && lock_ok),
        .load_code (lock_data),
        .chk_addr  (wr_addr),
        .code      (code),
        .rng       (rng),
        .hit       (hit)
    );

    // Loading a new code is not gated by the present range.
    assign lock_ok    = wel && hw_allow && !abort;
    assign wr_allowed = lock_ok && !hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_start_q   <= 1'b0;
            lock_start_q <= 1'b0;
        end else begin
            wr_start_q   <= wr_go && wr_allowed;
            lock_start_q <= lock_go && lock_ok;
        end
    end

    assign wr_start   = wr_start_q;
    assign lock_start = lock_start_q;
    assign lock_code  = code;
    assign prot_en    = rng.en;
    assign prot_lo    = rng.lo[ADDR_W-1:0];
    assign prot_hi    = rng.hi[ADDR_W-1:0];

    assert_start_needs_latch_R6: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> $past(wel && hw_allow && !abort));

    assert_locked_page_refused_R6: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> !$past(hit));

    assert_pin_low_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (lock_start || wr_start) |-> $past(hw_allow));

    assert_code_moves_on_load_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_code) |-> lock_start);

endmodule

// File: tb/test_wr_guard.sv
module test_wr_guard;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hw_allow = 1'b1, shift_busy = 1'b0, arm_cmd = 1'b0, bit_tick = 1'b0;
    logic          desel_edge = 1'b0, disarm_cmd = 1'b0, nv_done = 1'b0;
    logic          wr_go = 1'b0, lock_go = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [2:0]    lock_data = '0;
    logic          wel, prot_en, wr_allowed, wr_start, lock_start;
    logic [2:0]    lock_code;
    logic [AW-1:0] prot_lo, prot_hi;

    int n_chk = 0, n_bad = 0;
    bit m_wel = 0;
    int m_code = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wr_guard i_wr_guard (
        .clk(clk), .rst(rst), .hw_allow(hw_allow), .shift_busy(shift_busy),
        .arm_cmd(arm_cmd), .bit_tick(bit_tick), .desel_edge(desel_edge),
        .disarm_cmd(disarm_cmd), .nv_done(nv_done), .wr_go(wr_go), .wr_addr(wr_addr),
        .lock_go(lock_go), .lock_data(lock_data), .wel(wel), .lock_code(lock_code),
        .prot_en(prot_en), .prot_lo(prot_lo), .prot_hi(prot_hi),
        .wr_allowed(wr_allowed), .wr_start(wr_start), .lock_start(lock_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic void exp_rng(input int c, output bit en, output int lo, output int hi);
        en = 1;
        case (c)
            1: begin lo = 'h000; hi = 'h0FF; end
            2: begin lo = 'h100; hi = 'h1FF; end
            3: begin lo = 'h200; hi = 'h2FF; end
            4: begin lo = 'h300; hi = 'h3FF; end
            5: begin lo = 'h000; hi = 'h1FF; end
            6: begin lo = 'h000; hi = 'h00F; end
            7: begin lo = 'h3F0; hi = 'h3FF; end
            default: begin en = 0; lo = 0; hi = 0; end
        endcase
    endfunction

    function automatic bit exp_locked(input int c, input int a);
        bit en; int lo, hi;
        exp_rng(c, en, lo, hi);
        return en && a >= lo && a <= hi;
    endfunction

    task automatic arm(input bit interrupt);
        arm_cmd = 1; step(); arm_cmd = 0;
        if (interrupt) begin bit_tick = 1; step(); bit_tick = 0; end
        desel_edge = 1; step(); desel_edge = 0;
        if (!interrupt) m_wel = 1;
        chk(wel == m_wel, "R2 latch after arm", wel, m_wel);
    endtask

    task automatic finish_cycle();
        nv_done = 1; step(); nv_done = 0;
        m_wel = 0;
        chk(wel == 0, "R3 latch after nv_done", wel, 0);
    endtask

    task automatic wr(input int a, input bit abort_pending, input bit auto_done);
        bit e;
        e = m_wel && hw_allow && !abort_pending && !exp_locked(m_code, a);
        shift_busy = 1; wr_addr = AW'(a); step();
        wr_go = 1;
        #1 chk(wr_allowed == e, "R10 wr_allowed", wr_allowed, e);
        step(); wr_go = 0; shift_busy = 0;
        chk(wr_start == e, "R6 wr_start", wr_start, e);
        step();
        chk(wr_start == 0, "R6 single pulse", wr_start, 0);
        if (e && auto_done) finish_cycle();
    endtask

    task automatic ld(input int c);
        bit e;
        e = m_wel && hw_allow;
        shift_busy = 1; lock_data = 3'(c); step();
        lock_go = 1; step(); lock_go = 0; shift_busy = 0;
        if (e) m_code = c;
        chk(lock_start == e, "R9 lock_start", lock_start, e);
        chk(lock_code == 3'(m_code), "R9 lock_code", lock_code, m_code);
        if (e) finish_cycle();
    endtask

    task automatic chk_decode();
        bit en; int lo, hi;
        exp_rng(m_code, en, lo, hi);
        chk(prot_en == en, (m_code < 5) ? "R4 prot_en" : "R5 prot_en", prot_en, en);
        if (en) begin
            chk(prot_lo == AW'(lo), (m_code < 5) ? "R4 prot_lo" : "R5 prot_lo", prot_lo, lo);
            chk(prot_hi == AW'(hi), (m_code < 5) ? "R4 prot_hi" : "R5 prot_hi", prot_hi, hi);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        rst = 0; step();
        // R1 reset state
        chk(wel == 0, "R1 wel", wel, 0);
        chk(lock_code == 0, "R1 lock_code", lock_code, 0);
        chk(prot_en == 0, "R1 prot_en", prot_en, 0);
        chk(wr_start == 0 && lock_start == 0, "R1 starts", wr_start, 0);

        // R2 interrupted arm leaves latch clear; R6 write then refused
        arm(1);
        wr('h123, 0, 1);
        arm(0);
        // R3 disarm clears
        disarm_cmd = 1; step(); disarm_cmd = 0; m_wel = 0;
        chk(wel == 0, "R3 disarm", wel, 0);
        // R3 clear wins over set in the same cycle
        arm_cmd = 1; step(); arm_cmd = 0;
        desel_edge = 1; disarm_cmd = 1; step(); desel_edge = 0; disarm_cmd = 0;
        chk(wel == 0, "R3 clear beats set", wel, 0);

        // R4/R5 every code decoded
        for (int c = 0; c < 8; c++) begin
            arm(0); ld(c); chk_decode();
        end

        // R5/R6 page boundary corners
        arm(0); ld(6);
        arm(0); wr('h00A, 0, 1); wr('h010, 0, 1);
        arm(0); ld(7);
        arm(0); wr('h3F5, 0, 1); wr('h3EF, 0, 1);
        arm(0); ld(5);
        arm(0); wr('h1FF, 0, 1); wr('h200, 0, 1);
        // R9 load allowed while a range is locked
        arm(0); ld(2); chk_decode();

        // R7 pin low: write and load refused, latch still set/clearable
        arm(0);
        hw_allow = 0; step();
        wr('h380, 0, 1);
        ld(4);
        chk(wel == 1, "R7 latch kept", wel, 1);
        disarm_cmd = 1; step(); disarm_cmd = 0; m_wel = 0;
        chk(wel == 0, "R7 disarm works", wel, 0);
        arm(0);
        chk(wel == 1, "R7 arm works", wel, 1);
        hw_allow = 1; step();

        // R8 pin dip while shifting aborts, even after recovery
        shift_busy = 1; step();
        hw_allow = 0; step();
        hw_allow = 1; step();
        wr('h300, 1, 1);
        chk(wel == 1, "R8 latch kept after abort", wel, 1);
        wr('h300, 0, 0);
        // R8 pin dip during internal cycle has no effect
        hw_allow = 0; step(); hw_allow = 1; step();
        finish_cycle();
        arm(0);
        wr('h3C0, 0, 1);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom;
            if (r[3:0] == 0) begin arm(0); ld(int'($urandom % 8)); chk_decode(); end
            if (r[4]) arm(r[5]);
            hw_allow = (r[8:6] != 0); step();
            wr(int'($urandom % 1024), 0, 1);
            if (!hw_allow) begin hw_allow = 1; step(); end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule